// File: doc/BRIEF.md
# Transmit-Only Serial ROM Streamer

This block reads a small byte memory in an endless loop and sends it bit by bit onto an open-drain serial data line. A slow external strobe paces the bits. The strobe is resynchronised into the system clock domain, and each rising edge it produces moves the stream forward by one bit slot.

After reset, or after a restart pulse from the mode controller, the block first lets a fixed number of strobe edges pass with the line released. This is a silent synchronisation phase. Once it ends, the block sends byte after byte in ascending address order, most significant bit first. Each byte is followed by one released null slot. The address wraps from the top of the array back to zero.

The memory sits outside the block, behind a plain address/data read port. The mode controller can gate the output enable at any time. Gating does not disturb the sequencing.

Top module: `rom_streamer`

## Requirements
- R1: While reset is held and after it is released, `pad_oe` is 0, `pad_dat` is 1 and `mem_addr` is 0 until the first strobe edge.
- R2: After reset or restart, the first SYNC_EDGES (default 9) strobe rising edges leave `pad_oe` at 0.
- R3: Strobe rising edge number SYNC_EDGES+1 makes the block drive `pad_oe`=1 with `pad_dat` equal to bit 7 of the byte at address 0.
- R4: Each of the next seven edges presents the next lower bit of the same byte, so bits 7 down to 0 appear on 8 consecutive edges.
- R5: The edge after bit 0 of every byte opens a null slot: `pad_oe`=0 and `pad_dat`=1 (line released high). The edge after that begins the next byte.
- R6: Bytes go out in ascending address order. `mem_addr` steps by exactly one when a null slot opens, changes at no other time except restart, and wraps from 127 to 0, after which streaming carries on.
- R7: A one-cycle `restart` pulse sets `mem_addr` to 0 and returns the block to the silent phase. The next 9 edges are silent and the 10th drives bit 7 of address 0.
- R8: While `enable` is 0, `pad_oe` is 0 and `pad_dat` is 1, but the bit sequencing still advances on every edge. After `enable` returns to 1, the output shows the bit that the edge count calls for.
- R9: Each strobe rising edge changes the pad outputs exactly SYNC_STAGES+2 system clock cycles (default 4) after the strobe is first sampled high, and a held-high strobe counts as one edge. A strobe that is already high during reset does not count as an edge.
- R10: A byte is taken from `mem_rdata` on the edge that starts it. `mem_addr` holds that byte's address from the preceding null slot (or from restart) until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Output permission from the mode controller; 0 forces the line released |
| restart | input | 1 | One-cycle pulse that returns the block to the silent phase at address 0 |
| strobe_in | input | 1 | Asynchronous slow bit strobe; rising edges advance the stream |
| mem_addr | output | ADDR_W (7) | Read address to the byte memory |
| mem_rdata | input | BYTE_W (8) | Byte read from the memory at `mem_addr` |
| pad_oe | output | 1 | 1 while a data bit is driven onto the line |
| pad_dat | output | 1 | Bit value to drive; 1 whenever `pad_oe` is 0 |

## Verification
The bench walks through more than a full pass of the array, edge by edge, and compares every slot against an arithmetic model of the edge count. A sequencer that miscounts the silent phase would start its bytes one slot early or late, and a sequencer that drops the null slot would drift out of phase after the first byte. A wrong wrap would fetch the wrong byte after address 127, and a wrong bit order would reverse each frame. Separate passes restart the block mid-byte and gate the enable across frame boundaries, which exposes a restart that clears only part of the state or an enable that stalls sequencing. A cycle-exact latency probe on the first driven bit catches a synchroniser with too many or too few stages.

// File: rtl/rom_streamer_pkg.sv
package rom_streamer_pkg;

    // Position of the stream within the repeating frame.
    typedef enum logic [1:0] {
        PH_SILENT = 2'd0,
        PH_DATA   = 2'd1,
        PH_NULL   = 2'd2
    } phase_e;

    // What the sequencer asks the pad stage to do.
    typedef struct packed {
        logic drive;
        logic bit_val;
    } pad_req_t;

    // Pad value presented when the line is released.
    localparam logic RELEASED_LEVEL = 1'b1;

    // Width of a counter that must reach the value n.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/strobe_edge_detect.sv
module strobe_edge_detect #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_in,
    output logic edge_pulse
);
    localparam int unsigned MSB = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= strobe_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], strobe_in};
            end
        end
    endgenerate

    // Reset to "already high" so a strobe high at reset is not an edge.
    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= sync_q[MSB];
    end

    assign edge_pulse = sync_q[MSB] & ~prev_q;

    // R9
    edge_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        edge_pulse |=> !edge_pulse);

endmodule

// File: rtl/stream_sequencer.sv
module stream_sequencer
    import rom_streamer_pkg::*;
#(
    parameter int unsigned ADDR_W     = 7,
    parameter int unsigned BYTE_W     = 8,
    parameter int unsigned SYNC_EDGES = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              edge_pulse,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output phase_e            phase,
    output pad_req_t          pad_req
);
    localparam int unsigned CW = cnt_width(SYNC_EDGES);
    localparam int unsigned BW = cnt_width(BYTE_W - 1);
    localparam logic [CW-1:0] SYNC_LAST = CW'(SYNC_EDGES);
    localparam logic [BW-1:0] BIT_LAST  = BW'(BYTE_W - 1);

    logic [CW-1:0]     sync_cnt;
    logic [BW-1:0]     bit_idx;
    logic [BYTE_W-1:0] shreg;
    logic [ADDR_W-1:0] addr_q;
    phase_e            phase_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_q  <= PH_SILENT;
            sync_cnt <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            addr_q   <= '0;
        end else if (edge_pulse) begin
            case (phase_q)
                PH_SILENT: begin
                    if (sync_cnt == SYNC_LAST) begin
                        phase_q <= PH_DATA;
                        shreg   <= mem_rdata;
                        bit_idx <= '0;
                    end else begin
                        sync_cnt <= sync_cnt + 1'b1;
                    end
                end
                PH_DATA: begin
                    if (bit_idx == BIT_LAST) begin
                        phase_q <= PH_NULL;
                        addr_q  <= addr_q + 1'b1;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                        shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                    end
                end
                PH_NULL: begin
                    phase_q <= PH_DATA;
                    shreg   <= mem_rdata;
                    bit_idx <= '0;
                end
                default: phase_q <= PH_SILENT;
            endcase
        end
    end

    assign mem_addr        = addr_q;
    assign phase           = phase_q;
    assign pad_req.drive   = (phase_q == PH_DATA);
    assign pad_req.bit_val = shreg[BYTE_W-1];

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!edge_pulse && !restart) |=> $stable(mem_addr));

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        ((mem_addr != $past(mem_addr)) && !$past(restart))
            |-> (mem_addr == $past(mem_addr) + 1'b1));

    // R10
    addr_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_pulse && phase_q != PH_DATA && !restart) |=> $stable(mem_addr));

endmodule

// File: rtl/pad_stage.sv
module pad_stage
    import rom_streamer_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     enable,
    input  pad_req_t pad_req,
    output logic     pad_oe,
    output logic     pad_dat
);
    logic drive_now;

    assign drive_now = pad_req.drive & enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            pad_oe  <= 1'b0;
            pad_dat <= RELEASED_LEVEL;
        end else begin
            pad_oe  <= drive_now;
            pad_dat <= drive_now ? pad_req.bit_val : RELEASED_LEVEL;
        end
    end

endmodule

// File: rtl/rom_streamer.sv
module rom_streamer
    import rom_streamer_pkg::*;
#(
    parameter int unsigned ADDR_W      = 7,
    parameter int unsigned BYTE_W      = 8,
    parameter int unsigned SYNC_EDGES  = 9,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              restart,
    input  logic              strobe_in,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              pad_oe,
    output logic              pad_dat
);
    logic     edge_pulse;
    phase_e   phase;
    pad_req_t pad_req;

    strobe_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk        (clk),
        .rst        (rst),
        .strobe_in  (strobe_in),
        .edge_pulse (edge_pulse)
    );

    stream_sequencer #(
        .ADDR_W     (ADDR_W),
        .BYTE_W     (BYTE_W),
        .SYNC_EDGES (SYNC_EDGES)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .restart    (restart),
        .edge_pulse (edge_pulse),
        .mem_rdata  (mem_rdata),
        .mem_addr   (mem_addr),
        .phase      (phase),
        .pad_req    (pad_req)
    );

    pad_stage u_pad (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .pad_req (pad_req),
        .pad_oe  (pad_oe),
        .pad_dat (pad_dat)
    );

    // R2
    silent_phase_chk: assert property (@(posedge clk) disable iff (rst)
        pad_oe |-> ($past(phase) == PH_DATA));

    // R7
    restart_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(restart, 2) |-> !pad_oe);

    // R5
    released_level_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(phase) == PH_NULL) |-> (!pad_oe && pad_dat));

endmodule

// File: tb/rom_streamer_tb.sv
`timescale 1ns/1ps
module rom_streamer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b1;
    logic       restart = 1'b0;
    logic       strobe_in = 1'b0;
    logic [6:0] mem_addr;
    logic [7:0] mem_rdata;
    logic       pad_oe;
    logic       pad_dat;

    int total = 0;
    int fails = 0;
    int k = 0;          // strobe edges since reset/restart
    bit en_model = 1'b1;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    rom_streamer u_dut (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .restart   (restart),
        .strobe_in (strobe_in),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .pad_oe    (pad_oe),
        .pad_dat   (pad_dat)
    );

    function automatic int byte_of(input int a);
        return (a * 29 + 90) % 256;
    endfunction

    assign mem_rdata = 8'(byte_of(int'(mem_addr)));

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s edge=%0d actual=%0d expected=%0d", tag, k, act, exp);
        end
    endtask

    // Expected pad state and address after edge number n.
    task automatic check_edge(input int n);
        int j, pos, byt, eoe, edat, eaddr;
        string tag;
        if (n <= 9) begin
            eoe = 0; edat = 1; eaddr = 0; tag = "R2";
        end else begin
            j     = n - 10;
            pos   = j % 9;
            byt   = j / 9;
            eaddr = ((j + 1) / 9) % 128;
            if (pos < 8) begin
                eoe  = 1;
                edat = (byte_of(byt % 128) >> (7 - pos)) & 1;
                tag  = (n == 10) ? "R3" : "R4";
            end else begin
                eoe = 0; edat = 1; tag = "R5";
            end
        end
        if (!en_model) begin
            eoe = 0; edat = 1; tag = "R8";
        end
        chk({tag, " oe"}, int'(pad_oe), eoe);
        chk({tag, " dat"}, int'(pad_dat), edat);
        chk((eaddr == 0 && n > 10) ? "R6 wrap addr" : "R6 addr", int'(mem_addr), eaddr);
    endtask

    task automatic one_edge();
        @(negedge clk) strobe_in = 1'b1;
        repeat (6) @(negedge clk);
        k++;
        check_edge(k);
        strobe_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_edges(input int n);
        for (int i = 0; i < n; i++) one_edge();
    endtask

    task automatic do_restart();
        @(negedge clk) restart = 1'b1;
        @(negedge clk) restart = 1'b0;
        k = 0;
        chk("R7 addr cleared", int'(mem_addr), 0);
        @(negedge clk);
        chk("R7 oe released", int'(pad_oe), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk("R1 oe in reset", int'(pad_oe), 0);
        strobe_in = 1'b1;              // high during reset: not an edge (R9)
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (8) @(negedge clk);
        chk("R1 oe", int'(pad_oe), 0);
        chk("R1 dat", int'(pad_dat), 1);
        chk("R1 addr", int'(mem_addr), 0);
        strobe_in = 1'b0;
        repeat (4) @(negedge clk);

        // Full pass past wrap: 10 + 129 frames.
        run_edges(10 + 129 * 9 + 5);

        // Restart mid-byte, then latency probe on the 10th edge (R7, R9).
        do_restart();
        run_edges(9);
        @(negedge clk) strobe_in = 1'b1;
        repeat (3) @(posedge clk);
        #1 chk("R9 not yet", int'(pad_oe), 0);
        @(posedge clk);
        #1 chk("R9 at latency", int'(pad_oe), 1);
        repeat (3) @(negedge clk);
        k++;
        check_edge(k);
        strobe_in = 1'b0;
        repeat (4) @(negedge clk);
        run_edges(20);

        // Enable gating across frame boundaries (R8).
        @(negedge clk) enable = 1'b0;
        en_model = 1'b0;
        run_edges(22);
        @(negedge clk) enable = 1'b1;
        en_model = 1'b1;
        run_edges(27);

        // Restart while disabled-free streaming, second silent phase (R7).
        do_restart();
        run_edges(30);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule